// File: doc/BRIEF.md
# Write-Combining Store Buffer Pool

The block sits between a core's store path and a memory-side write port. Each store arrives with a byte address, a size code, up to eight data bytes, a memory-type tag and a streaming hint. Stores that may be combined are gathered into line buffers. Each line buffer covers one aligned 64-byte line and holds a data image and a byte-valid mask. All other stores leave at once as single masked line writes. Every write that leaves the block uses one valid/ready port and carries a line address, 64 data bytes and a 64-bit byte mask.

The pool holds `NUM_ENTRIES` slots, and `RESERVED` of them are kept for line-fill traffic. Only the remaining slots take part in combining. A buffer is written out in three cases: when all 64 of its bytes are valid, when the flush input is pulsed, or when a new line needs a slot while every slot is taken. In the last case the victim is the buffer allocated earliest. Buffered writes are never overtaken by an uncombined store to the same line. A store that would straddle two lines is refused with an error flag.

Top module: `wcb_pool`

## Requirements
- R1: A store is combinable when `st_mtype` is 1 (write-combining), or when it is 6 (write-back) and `st_stream` is 1. Every other code (0 uncacheable, 4 write-through, 5 write-protect, 6 without stream) is issued alone as one line write whose mask has one bit set per stored byte.
- R2: The line address is `st_addr[ADDR_W-1:6]` and the start lane is `st_addr[5:0]`. Size codes 0..3 mean 1, 2, 4 and 8 bytes. Store byte k (bits 8k+7:8k of `st_data`) lands in lane start+k. A combinable store does not cause a write by itself. The later writes leave memory holding the last value stored to each byte.
- R3: When a buffer holds all 64 bytes, it is written out with an all-ones mask without waiting for a flush.
- R4: A one-cycle `flush` pulse drains every valid buffer. `st_ready` is low in the cycle after the pulse and stays low until the drain ends.
- R5: At most `NUM_ENTRIES-RESERVED` lines are buffered (8 by default). A combinable store to a new line when no slot is free first writes out the buffer allocated earliest, and is accepted only after that. Merging into a buffer does not change its age.
- R6: A store with start lane + byte count > 64 is accepted with `st_err` high in the same cycle. It is dropped and produces no write.
- R7: An uncombined store whose line is buffered first causes that buffer to be written. Its own single write follows afterwards.
- R8: While `wr_valid` is high and `wr_ready` is low, the address, data and mask hold steady. Every write carries a non-zero mask.
- R9: After reset `wr_valid` is low and, with an uncacheable store presented, `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pulse: drain all buffers |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted on this edge when valid |
| st_addr | input | ADDR_W | Byte address |
| st_size | input | 2 | Size code: 1, 2, 4, 8 bytes |
| st_data | input | 64 | Store bytes, byte 0 in bits 7:0 |
| st_mtype | input | 3 | Memory type code |
| st_stream | input | 1 | Streaming (non-temporal) hint |
| st_err | output | 1 | Line-crossing store rejected |
| wr_valid | output | 1 | Line write valid |
| wr_ready | input | 1 | Downstream accepts the write |
| wr_addr | output | ADDR_W-6 | Line address |
| wr_data | output | 512 | Line data, lane b in bits 8b+7:8b |
| wr_mask | output | 64 | Byte enables |

## Verification
A drain started by `flush` can coincide with a store that is being accepted. The store's line is then allocated in the same edge that arms the drain, and it must be written out as well. The random phase sends flush pulses between stores while the downstream ready toggles at random. This keeps evictions, merges and flushes overlapping. Correctness is judged on the final contents of a bench memory built only from the emitted masked writes. That image is compared line by line with the image the accepted stores imply, which exposes any byte that was lost, written twice in the wrong order, or overtaken.

// File: rtl/wcb_pkg.sv
`timescale 1ns/1ps
package wcb_pkg;
  localparam int LINE_BYTES = 64;
  localparam int OFF_W      = 6;
  localparam int LINE_BITS  = LINE_BYTES * 8;

  typedef enum logic [2:0] {
    MT_UC = 3'd0,
    MT_WC = 3'd1,
    MT_WT = 3'd4,
    MT_WP = 3'd5,
    MT_WB = 3'd6
  } mem_type_e;
endpackage

// File: rtl/wcb_classify.sv
`timescale 1ns/1ps
module wcb_classify
  import wcb_pkg::*;
(
  input  logic [OFF_W-1:0]     off_i,
  input  logic [1:0]           size_i,
  input  logic [63:0]          data_i,
  input  logic [2:0]           mtype_i,
  input  logic                 stream_i,
  output logic                 comb_o,
  output logic                 cross_o,
  output logic [LINE_BYTES-1:0] mask_o,
  output logic [LINE_BITS-1:0]  ldata_o
);
  logic [6:0]  nbytes;
  logic [63:0] dmask;

  always_comb begin
    nbytes  = 7'd1 << size_i;
    comb_o  = (mtype_i == MT_WC) || ((mtype_i == MT_WB) && stream_i);
    cross_o = ({1'b0, off_i} + nbytes) > 7'd64;
    mask_o  = ((64'd1 << nbytes) - 64'd1) << off_i;
    for (int k = 0; k < 8; k++) begin
      dmask[k*8 +: 8] = (7'(k) < nbytes) ? data_i[k*8 +: 8] : 8'h00;
    end
    ldata_o = {448'd0, dmask} << {off_i, 3'b000};
  end
endmodule

// File: rtl/wcb_entry.sv
`timescale 1ns/1ps
module wcb_entry
  import wcb_pkg::*;
#(
  parameter int LW = 26,
  parameter int RW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_i,
  input  logic                  merge_i,
  input  logic                  evict_i,
  input  logic                  alloc_any_i,
  input  logic                  evict_any_i,
  input  logic [RW-1:0]         evict_rank_i,
  input  logic [LW-1:0]         line_i,
  input  logic [LINE_BYTES-1:0] mask_i,
  input  logic [LINE_BITS-1:0]  data_i,
  output logic                  valid_o,
  output logic [LW-1:0]         line_o,
  output logic [LINE_BYTES-1:0] mask_o,
  output logic [LINE_BITS-1:0]  data_o,
  output logic [RW-1:0]         rank_o
);
  logic                  valid_q, valid_d;
  logic [RW-1:0]         rank_q, rank_d;
  logic [LINE_BYTES-1:0] mask_q, mask_d;
  logic [LINE_BITS-1:0]  data_q, data_d;
  logic [LW-1:0]         line_q;
  logic [LINE_BITS-1:0]  bit_en;
  logic                  data_en;

  always_comb begin
    for (int b = 0; b < LINE_BYTES; b++) bit_en[b*8 +: 8] = {8{mask_i[b]}};
    valid_d = valid_q;
    rank_d  = rank_q;
    mask_d  = mask_q;
    data_d  = data_q;
    data_en = alloc_i | merge_i;
    if (alloc_i) begin
      valid_d = 1'b1;
      rank_d  = '0;
      mask_d  = mask_i;
      data_d  = data_i;
    end else begin
      if (merge_i) begin
        mask_d = mask_q | mask_i;
        data_d = (data_q & ~bit_en) | (data_i & bit_en);
      end
      if (evict_i) valid_d = 1'b0;
      if (valid_q && alloc_any_i) rank_d = rank_q + 1'b1;
      else if (valid_q && evict_any_i && (rank_q > evict_rank_i)) rank_d = rank_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rank_q  <= '0;
      mask_q  <= '0;
    end else begin
      valid_q <= valid_d;
      rank_q  <= rank_d;
      mask_q  <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_d;
    if (alloc_i) line_q <= line_i;
  end

  assign valid_o = valid_q;
  assign line_o  = line_q;
  assign mask_o  = mask_q;
  assign data_o  = data_q;
  assign rank_o  = rank_q;
endmodule

// File: rtl/wcb_oldest.sv
`timescale 1ns/1ps
module wcb_oldest #(
  parameter int NC = 8,
  parameter int IW = 3,
  parameter int RW = 3
) (
  input  logic [NC-1:0]         valid_i,
  input  logic [NC-1:0][RW-1:0] rank_i,
  output logic [IW-1:0]         idx_o
);
  logic [RW-1:0] best;
  logic          seen;

  always_comb begin
    idx_o = '0;
    best  = '0;
    seen  = 1'b0;
    for (int i = 0; i < NC; i++) begin
      if (valid_i[i] && (!seen || rank_i[i] > best)) begin
        seen  = 1'b1;
        best  = rank_i[i];
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wcb_pool.sv
`timescale 1ns/1ps
module wcb_pool
  import wcb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_ENTRIES = 10,
  parameter int RESERVED    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [1:0]            st_size,
  input  logic [63:0]           st_data,
  input  logic [2:0]            st_mtype,
  input  logic                  st_stream,
  output logic                  st_err,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [ADDR_W-OFF_W-1:0] wr_addr,
  output logic [LINE_BITS-1:0]  wr_data,
  output logic [LINE_BYTES-1:0] wr_mask
);
  localparam int NC = NUM_ENTRIES - RESERVED;
  localparam int IW = (NC > 1) ? $clog2(NC) : 1;
  localparam int RW = IW;
  localparam int LW = ADDR_W - OFF_W;

  logic                  cls_comb, cls_cross;
  logic [LINE_BYTES-1:0] cls_mask;
  logic [LINE_BITS-1:0]  cls_data;
  logic [LW-1:0]         st_line;

  logic [NC-1:0]                 valid_w;
  logic [NC-1:0][LW-1:0]         line_w;
  logic [NC-1:0][LINE_BYTES-1:0] mask_w;
  logic [NC-1:0][LINE_BITS-1:0]  data_w;
  logic [NC-1:0][RW-1:0]         rank_w;

  logic          hit_any, free_any, full_any, valid_any;
  logic [IW-1:0] hit_idx, free_idx, full_idx, old_idx, evict_idx;
  logic          evict_en, single_en, alloc_en, merge_en, rdy;
  logic          drain_q, drain_d;
  logic          out_valid_q, out_valid_d, out_free, out_load;
  logic [LW-1:0]         out_line_q, out_line_d;
  logic [LINE_BYTES-1:0] out_mask_q, out_mask_d;
  logic [LINE_BITS-1:0]  out_data_q, out_data_d;

  assign st_line = st_addr[ADDR_W-1:OFF_W];

  wcb_classify i_classify (
    .off_i    (st_addr[OFF_W-1:0]),
    .size_i   (st_size),
    .data_i   (st_data),
    .mtype_i  (st_mtype),
    .stream_i (st_stream),
    .comb_o   (cls_comb),
    .cross_o  (cls_cross),
    .mask_o   (cls_mask),
    .ldata_o  (cls_data)
  );

  for (genvar g = 0; g < NC; g++) begin : g_entry
    wcb_entry #(.LW(LW), .RW(RW)) i_entry (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc_en && (free_idx == IW'(g))),
      .merge_i      (merge_en && (hit_idx == IW'(g))),
      .evict_i      (evict_en && (evict_idx == IW'(g))),
      .alloc_any_i  (alloc_en),
      .evict_any_i  (evict_en),
      .evict_rank_i (rank_w[evict_idx]),
      .line_i       (st_line),
      .mask_i       (cls_mask),
      .data_i       (cls_data),
      .valid_o      (valid_w[g]),
      .line_o       (line_w[g]),
      .mask_o       (mask_w[g]),
      .data_o       (data_w[g]),
      .rank_o       (rank_w[g])
    );
  end

  wcb_oldest #(.NC(NC), .IW(IW), .RW(RW)) i_oldest (
    .valid_i (valid_w),
    .rank_i  (rank_w),
    .idx_o   (old_idx)
  );

  // lookup: lowest index wins for hit, free and full
  always_comb begin
    hit_any = 1'b0; hit_idx = '0;
    free_any = 1'b0; free_idx = '0;
    full_any = 1'b0; full_idx = '0;
    valid_any = |valid_w;
    for (int i = NC - 1; i >= 0; i--) begin
      if (valid_w[i] && (line_w[i] == st_line)) begin hit_any = 1'b1; hit_idx = IW'(i); end
      if (!valid_w[i]) begin free_any = 1'b1; free_idx = IW'(i); end
      if (valid_w[i] && (&mask_w[i])) begin full_any = 1'b1; full_idx = IW'(i); end
    end
  end

  assign out_free = !out_valid_q || wr_ready;

  // decision
  always_comb begin
    evict_en = 1'b0; evict_idx = '0; single_en = 1'b0;
    alloc_en = 1'b0; merge_en = 1'b0; rdy = 1'b0;
    if (full_any) begin
      evict_en  = out_free;
      evict_idx = full_idx;
    end else if (drain_q) begin
      evict_en  = out_free && valid_any;
      evict_idx = old_idx;
    end else if (cls_cross) begin
      rdy = 1'b1;
    end else if (cls_comb) begin
      if (hit_any) begin
        rdy = 1'b1; merge_en = st_valid;
      end else if (free_any) begin
        rdy = 1'b1; alloc_en = st_valid;
      end else begin
        evict_en = st_valid && out_free; evict_idx = old_idx;
      end
    end else if (hit_any) begin
      evict_en = st_valid && out_free; evict_idx = hit_idx;
    end else begin
      rdy = out_free; single_en = st_valid && out_free;
    end
    drain_d = flush || (drain_q && valid_any);
  end

  // output register next state
  always_comb begin
    out_load    = evict_en || single_en;
    out_valid_d = out_load || (out_valid_q && !wr_ready);
    out_line_d  = out_line_q;
    out_mask_d  = out_mask_q;
    out_data_d  = out_data_q;
    if (evict_en) begin
      out_line_d = line_w[evict_idx];
      out_mask_d = mask_w[evict_idx];
      out_data_d = data_w[evict_idx];
    end else if (single_en) begin
      out_line_d = st_line;
      out_mask_d = cls_mask;
      out_data_d = cls_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      drain_q     <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      drain_q     <= drain_d;
    end
  end

  always_ff @(posedge clk) begin
    if (out_load) begin
      out_line_q <= out_line_d;
      out_mask_q <= out_mask_d;
      out_data_q <= out_data_d;
    end
  end

  assign st_ready = rdy;
  assign st_err   = st_valid && rdy && cls_cross;
  assign wr_valid = out_valid_q;
  assign wr_addr  = out_line_q;
  assign wr_mask  = out_mask_q;
  assign wr_data  = out_data_q;
endmodule

// File: rtl/wcb_pool_chk.sv
`timescale 1ns/1ps
module wcb_pool_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              st_valid,
  input logic              st_ready,
  input logic [ADDR_W-1:0] st_addr,
  input logic [1:0]        st_size,
  input logic [2:0]        st_mtype,
  input logic              st_stream,
  input logic              st_err,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-7:0] wr_addr,
  input logic [511:0]      wr_data,
  input logic [63:0]       wr_mask
);
  logic st_comb, st_cross, st_take;
  assign st_comb  = (st_mtype == 3'd1) || ((st_mtype == 3'd6) && st_stream);
  assign st_cross = ({1'b0, st_addr[5:0]} + (7'd1 << st_size)) > 7'd64;
  assign st_take  = st_valid && st_ready;

  p_err_cross_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> (st_take && st_cross));

  p_err_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_err && !wr_valid) |=> !wr_valid);

  p_single_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_take && !st_comb && !st_cross) |=>
      (wr_valid && ($countones(wr_mask) == (1 << $past(st_size)))));

  p_comb_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_take && st_comb && !st_cross && !wr_valid) |=> !wr_valid);

  p_flush_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !st_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_mask) && $stable(wr_data)));

  p_mask_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_mask != 64'd0));
endmodule

bind wcb_pool wcb_pool_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .st_addr   (st_addr),
  .st_size   (st_size),
  .st_mtype  (st_mtype),
  .st_stream (st_stream),
  .st_err    (st_err),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_mask   (wr_mask)
);

// File: tb/test_wcb_pool.sv
`timescale 1ns/1ps
module test_wcb_pool;
  logic         clk = 1'b0;
  logic         rst_n, flush, st_valid, st_ready, st_stream, st_err;
  logic [31:0]  st_addr;
  logic [1:0]   st_size;
  logic [63:0]  st_data;
  logic [2:0]   st_mtype;
  logic         wr_valid, wr_ready;
  logic [25:0]  wr_addr;
  logic [511:0] wr_data;
  logic [63:0]  wr_mask;

  always #2.5 clk = ~clk;

  wcb_pool i_wcb_pool (
    .clk(clk), .rst_n(rst_n), .flush(flush), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_size(st_size), .st_data(st_data), .st_mtype(st_mtype),
    .st_stream(st_stream), .st_err(st_err), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask)
  );

  int errors = 0, checks = 0, wr_count = 0;
  bit done = 1'b0, rnd_ready = 1'b0, pend = 1'b0;
  byte unsigned exp_mem [1024];
  byte unsigned dev_mem [1024];
  logic [25:0]  last_addr, prev_addr, s_addr;
  logic [63:0]  last_mask, prev_mask, s_mask;
  logic [511:0] s_data;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit crosses(input logic [31:0] a, input logic [1:0] sz);
    return (int'(a[5:0]) + (1 << sz)) > 64;
  endfunction

  // downstream model: random ready, memory image, hold check
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) check("R8 hold", {63'd0, (wr_valid && wr_addr == s_addr &&
                      wr_mask == s_mask && wr_data == s_data)}, 64'd1);
      wr_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
      if (wr_valid && wr_ready) begin
        for (int b = 0; b < 64; b++) begin
          if (wr_mask[b] && (int'(wr_addr) * 64 + b) < 1024)
            dev_mem[int'(wr_addr) * 64 + b] = wr_data[b*8 +: 8];
        end
        prev_addr = last_addr; prev_mask = last_mask;
        last_addr = wr_addr;   last_mask = wr_mask;
        wr_count++;
        pend = 1'b0;
      end else if (wr_valid) begin
        pend = 1'b1; s_addr = wr_addr; s_mask = wr_mask; s_data = wr_data;
      end else pend = 1'b0;
    end
  end

  task automatic store(input logic [31:0] a, input logic [1:0] sz, input logic [63:0] d,
                       input logic [2:0] mt, input bit ns);
    bit e;
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_size = sz; st_data = d; st_mtype = mt; st_stream = ns;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    e = st_err;
    if (!crosses(a, sz)) begin
      for (int k = 0; k < (1 << sz); k++) exp_mem[a + k] = d[k*8 +: 8];
    end
    @(posedge clk);
    #1 st_valid = 1'b0;
    check("R6 err flag", {63'd0, e}, {63'd0, crosses(a, sz)});
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk); #1;
    check("R4 stall after flush", {63'd0, st_ready}, 64'd0);
    while (!(st_ready && !wr_valid)) begin @(negedge clk); #1; end
    settle(1);
  endtask

  initial begin
    int c0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; flush = 1'b0; st_valid = 1'b0; st_addr = '0; st_size = '0;
    st_data = '0; st_mtype = 3'd0; st_stream = 1'b0; wr_ready = 1'b1;
    for (int i = 0; i < 1024; i++) begin exp_mem[i] = 8'h00; dev_mem[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R9 reset state
    check("R9 wr_valid", {63'd0, wr_valid}, 64'd0);
    check("R9 st_ready", {63'd0, st_ready}, 64'd1);

    // R1 uncacheable single write, lanes 8..11
    c0 = wr_count;
    store(32'h48, 2'd2, 64'hAABBCCDD, 3'd0, 1'b0);
    settle(3);
    check("R1 UC write count", 64'(wr_count - c0), 64'd1);
    check("R2 UC mask", last_mask, 64'h0000_0000_0000_0F00);
    check("R2 UC line", 64'(last_addr), 64'd1);

    // R6 crossing store is dropped
    c0 = wr_count;
    store(32'h3E, 2'd2, 64'h11223344, 3'd1, 1'b0);
    settle(4);
    check("R6 no write", 64'(wr_count - c0), 64'd0);

    // R3 full line written out
    c0 = wr_count;
    for (int k = 0; k < 8; k++) store(32'h80 + 32'(k * 8), 2'd3, {32'(k), 32'hC0DE0000 + 32'(k)}, 3'd1, 1'b0);
    settle(4);
    check("R3 full count", 64'(wr_count - c0), 64'd1);
    check("R3 full mask", last_mask, {64{1'b1}});
    check("R3 full line", 64'(last_addr), 64'd2);

    // R1 write-back: streaming buffered, plain issued alone
    c0 = wr_count;
    store(32'hC0, 2'd0, 64'h5A, 3'd6, 1'b1);
    settle(4);
    check("R1 WB stream buffered", 64'(wr_count - c0), 64'd0);
    store(32'h100, 2'd1, 64'h7788, 3'd6, 1'b0);
    settle(4);
    check("R1 WB plain single", 64'(wr_count - c0), 64'd1);

    // R7 uncombined store drains matching buffer first
    c0 = wr_count;
    store(32'h144, 2'd1, 64'h1234, 3'd1, 1'b0);
    settle(3);
    check("R7 WC buffered", 64'(wr_count - c0), 64'd0);
    store(32'h150, 2'd0, 64'h99, 3'd5, 1'b0);
    settle(4);
    check("R7 two writes", 64'(wr_count - c0), 64'd2);
    check("R7 buffer first mask", prev_mask, 64'h30);
    check("R7 buffer first line", 64'(prev_addr), 64'd5);
    check("R7 single after", last_mask, 64'h1_0000);

    do_flush();

    // R5 capacity and oldest-first eviction
    c0 = wr_count;
    for (int l = 0; l < 8; l++) store(32'(l * 64 + 1), 2'd0, 64'(8'h40 + l), 3'd1, 1'b0);
    settle(3);
    check("R5 eight buffered", 64'(wr_count - c0), 64'd0);
    store(32'(8 * 64 + 2), 2'd0, 64'hE8, 3'd1, 1'b0);
    settle(3);
    check("R5 victim count", 64'(wr_count - c0), 64'd1);
    check("R5 victim oldest", 64'(last_addr), 64'd0);
    store(32'(1 * 64 + 9), 2'd0, 64'hE1, 3'd1, 1'b0);
    store(32'(9 * 64 + 3), 2'd0, 64'hE9, 3'd1, 1'b0);
    settle(3);
    check("R5 merge keeps age", 64'(last_addr), 64'd1);

    // R4 flush drains all eight
    c0 = wr_count;
    do_flush();
    check("R4 drained all", 64'(wr_count - c0), 64'd8);

    // random phase with stalling downstream
    rnd_ready = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [2:0] mt;
      case ($urandom % 8)
        0: mt = 3'd0; 1: mt = 3'd4; 2: mt = 3'd5; 3: mt = 3'd6;
        default: mt = 3'd1;
      endcase
      store(32'($urandom % 1024), 2'($urandom % 4), {$urandom, $urandom}, mt, 1'($urandom % 2));
      if (($urandom % 40) == 0) do_flush();
    end
    do_flush();
    rnd_ready = 1'b0;
    settle(2);
    for (int l = 0; l < 16; l++) begin
      int bad = 0;
      for (int b = 0; b < 64; b++) if (dev_mem[l*64 + b] != exp_mem[l*64 + b]) bad++;
      check($sformatf("R2 R7 memory line %0d mismatched bytes", l), 64'(bad), 64'd0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule